// File: doc/BRIEF.md
# Negotiation progress status register

This block sits beside a link negotiation state machine and turns its 4-bit state code into a 16-bit management status word. It holds a high-water mark of the negotiation state. While negotiation is enabled, the mark only moves to a code that is numerically larger than the one it holds. The block also holds a sticky flag that records loss of the receive signal while the link runs at 100 Mb/s.

A management front end reads the word by pulsing a one-clock read strobe. The word seen during the strobe cycle is the stored value. On the edge that closes the read, two updates take effect. The history mark is reloaded with the live state code, not cleared, so the next read reports progress from that point on. The loss flag is cleared, unless the signal is still lost during the read.

The history tracker chooses one action per clock: CLEAR when negotiation is disabled, RELOAD on a read, RAISE when the code exceeds the mark, and HOLD otherwise. The loss latch is a two-state machine. It moves from SIG_CLEAR to SIG_LATCHED on a 100 Mb/s loss. It moves from SIG_LATCHED back to SIG_CLEAR on a read cycle in which no loss is present. It stays SIG_LATCHED otherwise.

Top module: `nego_status_reg`

## Requirements
- R1: After reset the register word reads 16'h0000.
- R2: With negotiation enabled and no read, the history takes the state code on the next clock whenever the code is strictly greater than the stored history.
- R3: With negotiation enabled and no read, a state code less than or equal to the stored history leaves the history unchanged.
- R4: During a read strobe cycle the word shows the value held before that read. On the next clock the history equals the live state code sampled in the read cycle, even if that code is smaller.
- R5: While negotiation is disabled, the history becomes zero on the next clock and stays zero, reads included.
- R6: Bit 4 carries history bit 3, the completion bit, which is set for code 1000. Bits 13:11 carry history bits 2:0. The state codes are Idle 0000, parallel detect 0001, parallel detect fail 0010, abilities matched 0011, acknowledge fail 0100, acknowledge matched 0101, consistency fail 0110, consistency matched 0111, done 1000.
- R7: Bit 10, the loss flag, becomes 1 on the clock after a cycle in which the 100 Mb/s flag is 1 and receive-valid is 0. It stays 1 after the signal recovers, until a read.
- R8: In 10 Mb/s mode (100 Mb/s flag 0), a receive-valid of 0 never sets the loss flag.
- R9: A read clears the loss flag on the next clock. If the signal is lost in 100 Mb/s mode during the read cycle, the flag is 1 on the next clock instead.
- R10: Bits 15:14, 9:5 and 3:0 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| neg_en | input | 1 | Negotiation enable |
| state_code | input | 4 | Live negotiation state code |
| rx_sig_ok | input | 1 | Receive signal valid level |
| mode_100m | input | 1 | 1 = 100 Mb/s mode, 0 = 10 Mb/s mode |
| rd_stb | input | 1 | One-clock register read strobe |
| reg_word | output | 16 | Assembled status word |

## Verification
Every input is registered once before it reaches the word. A stimulus applied in one cycle therefore appears in the history field and the loss flag exactly one clock later, and the word is a plain combinational view of those two registers. The bench drives inputs at the falling edge and moves its model on the following rising edge. It compares at the next falling edge, so a read strobe cycle is checked against the value before the update, and the update is checked one cycle later.

// File: rtl/nego_status_pkg.sv
package nego_status_pkg;

    // Negotiation state codes as seen on state_code
    typedef enum logic [3:0] {
        NEG_IDLE      = 4'd0,
        NEG_PAR_DET   = 4'd1,
        NEG_PAR_FAIL  = 4'd2,
        NEG_ABIL_MATCH= 4'd3,
        NEG_ACK_FAIL  = 4'd4,
        NEG_ACK_MATCH = 4'd5,
        NEG_CONS_FAIL = 4'd6,
        NEG_CONS_MATCH= 4'd7,
        NEG_DONE      = 4'd8
    } neg_state_e;

    // Per-clock action of the history tracker
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_RAISE  = 2'd1,
        ACT_RELOAD = 2'd2,
        ACT_CLEAR  = 2'd3
    } hist_act_e;

    // Loss latch states
    typedef enum logic {
        SIG_CLEAR   = 1'b0,
        SIG_LATCHED = 1'b1
    } loss_state_e;

endpackage

// File: rtl/nego_hist_track.sv
module nego_hist_track
    import nego_status_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              neg_en,
    input  logic [CODE_W-1:0] state_code,
    input  logic              rd_stb,
    output logic [CODE_W-1:0] hist
);

    hist_act_e         act;
    logic [CODE_W-1:0] hist_q;
    logic [CODE_W-1:0] hist_d;

    // Decision: priority disable > read > raise > hold
    always_comb begin
        if (!neg_en)
            act = ACT_CLEAR;
        else if (rd_stb)
            act = ACT_RELOAD;
        else if (state_code > hist_q)
            act = ACT_RAISE;
        else
            act = ACT_HOLD;
    end

    always_comb begin
        unique case (act)
            ACT_CLEAR:  hist_d = '0;
            ACT_RELOAD: hist_d = state_code;
            ACT_RAISE:  hist_d = state_code;
            ACT_HOLD:   hist_d = hist_q;
            default:    hist_d = hist_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hist_q <= '0;
        else
            hist_q <= hist_d;
    end

    assign hist = hist_q;

endmodule

// File: rtl/nego_loss_latch.sv
module nego_loss_latch
    import nego_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_sig_ok,
    input  logic mode_100m,
    input  logic rd_stb,
    output logic lost
);

    loss_state_e state_q;
    loss_state_e state_d;
    logic        loss_now;

    // Loss only has meaning in 100 Mb/s mode
    assign loss_now = mode_100m && !rx_sig_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SIG_CLEAR;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SIG_CLEAR:   if (loss_now) state_d = SIG_LATCHED;
            SIG_LATCHED: if (rd_stb && !loss_now) state_d = SIG_CLEAR;
            default:     state_d = SIG_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SIG_LATCHED: lost = 1'b1;
            default:     lost = 1'b0;
        endcase
    end

endmodule

// File: rtl/nego_word_pack.sv
module nego_word_pack #(
    parameter int CODE_W   = 4,
    parameter int REG_W    = 16,
    parameter int CPL_BIT  = 4,
    parameter int LOW_LSB  = 11,
    parameter int LOST_BIT = 10
) (
    input  logic [CODE_W-1:0] hist,
    input  logic              lost,
    output logic [REG_W-1:0]  word
);

    localparam int LOW_W = CODE_W - 1;

    always_comb begin
        word                     = '0;
        word[CPL_BIT]            = hist[CODE_W-1];
        word[LOW_LSB +: LOW_W]   = hist[LOW_W-1:0];
        word[LOST_BIT]           = lost;
    end

endmodule

// File: rtl/nego_status_reg.sv
module nego_status_reg #(
    parameter int CODE_W   = 4,
    parameter int REG_W    = 16,
    parameter int CPL_BIT  = 4,
    parameter int LOW_LSB  = 11,
    parameter int LOST_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              neg_en,
    input  logic [CODE_W-1:0] state_code,
    input  logic              rx_sig_ok,
    input  logic              mode_100m,
    input  logic              rd_stb,
    output logic [REG_W-1:0]  reg_word
);

    logic [CODE_W-1:0] hist;
    logic              lost;

    nego_hist_track #(.CODE_W(CODE_W)) hist_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .neg_en     (neg_en),
        .state_code (state_code),
        .rd_stb     (rd_stb),
        .hist       (hist)
    );

    nego_loss_latch loss_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_sig_ok (rx_sig_ok),
        .mode_100m (mode_100m),
        .rd_stb    (rd_stb),
        .lost      (lost)
    );

    nego_word_pack #(
        .CODE_W   (CODE_W),
        .REG_W    (REG_W),
        .CPL_BIT  (CPL_BIT),
        .LOW_LSB  (LOW_LSB),
        .LOST_BIT (LOST_BIT)
    ) pack_i (
        .hist (hist),
        .lost (lost),
        .word (reg_word)
    );

endmodule

// File: rtl/nego_status_chk.sv
module nego_status_chk #(
    parameter int CODE_W   = 4,
    parameter int REG_W    = 16,
    parameter int CPL_BIT  = 4,
    parameter int LOW_LSB  = 11,
    parameter int LOST_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              neg_en,
    input logic [CODE_W-1:0] state_code,
    input logic              rx_sig_ok,
    input logic              mode_100m,
    input logic              rd_stb,
    input logic [REG_W-1:0]  reg_word
);

    localparam int LOW_W = CODE_W - 1;

    logic [CODE_W-1:0] fld;
    logic              lost_b;
    logic [REG_W-1:0]  used_mask;

    always_comb begin
        fld       = {reg_word[CPL_BIT], reg_word[LOW_LSB +: LOW_W]};
        lost_b    = reg_word[LOST_BIT];
        used_mask = '0;
        used_mask[CPL_BIT]          = 1'b1;
        used_mask[LOW_LSB +: LOW_W] = '1;
        used_mask[LOST_BIT]         = 1'b1;
    end

    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_word & ~used_mask) == '0);

    assert_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_en && !rd_stb) |=> fld >= $past(fld));

    assert_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_en && !rd_stb && state_code > fld) |=> fld == $past(state_code));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_en && rd_stb) |=> fld == $past(state_code));

    assert_disabled_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !neg_en |=> fld == '0);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_b && !rd_stb) |=> lost_b);

    assert_no_set_10m_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lost_b && !mode_100m) |=> !lost_b);

    assert_reset_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && mode_100m && !rx_sig_ok) |=> lost_b);

endmodule

bind nego_status_reg nego_status_chk #(
    .CODE_W   (CODE_W),
    .REG_W    (REG_W),
    .CPL_BIT  (CPL_BIT),
    .LOW_LSB  (LOW_LSB),
    .LOST_BIT (LOST_BIT)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .neg_en     (neg_en),
    .state_code (state_code),
    .rx_sig_ok  (rx_sig_ok),
    .mode_100m  (mode_100m),
    .rd_stb     (rd_stb),
    .reg_word   (reg_word)
);

// File: tb/nego_status_reg_tb_top.sv
`timescale 1ns/1ps
module nego_status_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        neg_en = 1'b0;
    logic [3:0]  state_code = 4'd0;
    logic        rx_sig_ok = 1'b1;
    logic        mode_100m = 1'b1;
    logic        rd_stb = 1'b0;
    logic [15:0] reg_word;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [3:0]  m_hist = 4'd0;
    logic        m_lost = 1'b0;
    int unsigned seed_v;

    always #5 clk = ~clk;

    nego_status_reg dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .neg_en     (neg_en),
        .state_code (state_code),
        .rx_sig_ok  (rx_sig_ok),
        .mode_100m  (mode_100m),
        .rd_stb     (rd_stb),
        .reg_word   (reg_word)
    );

    function automatic logic [15:0] pack(input logic [3:0] h, input logic l);
        logic [15:0] w;
        w = 16'h0000;
        w[4]     = h[3];
        w[13:11] = h[2:0];
        w[10]    = l;
        return w;
    endfunction

    task automatic check(input string tag_h, input string tag_l);
        logic [15:0] e;
        e = pack(m_hist, m_lost);
        n_chk++;
        if ({reg_word[4], reg_word[13:11]} !== m_hist) begin
            n_bad++;
            $display("FAIL %s history act=%h exp=%h", tag_h,
                     {reg_word[4], reg_word[13:11]}, m_hist);
        end
        n_chk++;
        if (reg_word[10] !== m_lost) begin
            n_bad++;
            $display("FAIL %s loss act=%b exp=%b", tag_l, reg_word[10], m_lost);
        end
        n_chk++;
        if ((reg_word & 16'hC3EF) !== (e & 16'hC3EF)) begin
            n_bad++;
            $display("FAIL R10 unused act=%h exp=%h", reg_word & 16'hC3EF, 16'h0000);
        end
    endtask

    // Drive at negedge, model steps on posedge, compare at next negedge
    task automatic step(input logic en, input logic [3:0] c, input logic ok,
                        input logic m, input logic rd,
                        input string tag_h, input string tag_l);
        neg_en = en; state_code = c; rx_sig_ok = ok; mode_100m = m; rd_stb = rd;
        @(posedge clk);
        if (!en)                m_hist = 4'd0;
        else if (rd)            m_hist = c;
        else if (c > m_hist)    m_hist = c;
        if (rd) m_lost = m && !ok;
        else    m_lost = m_lost | (m && !ok);
        @(negedge clk);
        check(tag_h, tag_l);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        seed_v = 32'd12345;
        void'($urandom(seed_v));
        repeat (3) @(negedge clk);
        n_chk++;
        if (reg_word !== 16'h0000) begin
            n_bad++;
            $display("FAIL R1 reset word act=%h exp=%h", reg_word, 16'h0000);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (reg_word !== 16'h0000) begin
            n_bad++;
            $display("FAIL R1 after reset act=%h exp=%h", reg_word, 16'h0000);
        end

        // Directed: progress up through the codes
        step(1, 4'd1, 1, 1, 0, "R2", "R7");
        step(1, 4'd3, 1, 1, 0, "R2", "R7");
        step(1, 4'd2, 1, 1, 0, "R3", "R7");
        step(1, 4'd3, 1, 1, 0, "R3", "R7");
        step(1, 4'd7, 1, 1, 0, "R6", "R7");
        step(1, 4'd8, 1, 1, 0, "R6", "R7");
        n_chk++;
        if (reg_word !== 16'h0010) begin
            n_bad++;
            $display("FAIL R6 done word act=%h exp=%h", reg_word, 16'h0010);
        end
        // Read: word shows old value during strobe, then reloads a smaller code
        neg_en = 1; state_code = 4'd5; rd_stb = 1;
        #1;
        n_chk++;
        if (reg_word !== 16'h0010) begin
            n_bad++;
            $display("FAIL R4 read-cycle word act=%h exp=%h", reg_word, 16'h0010);
        end
        step(1, 4'd5, 1, 1, 1, "R4", "R9");
        step(1, 4'd4, 1, 1, 0, "R4", "R9");
        // Disable clears
        step(0, 4'd7, 1, 1, 0, "R5", "R7");
        step(0, 4'd8, 1, 1, 1, "R5", "R9");
        // Loss sets and sticks
        step(1, 4'd0, 0, 1, 0, "R3", "R7");
        step(1, 4'd0, 1, 1, 0, "R3", "R7");
        step(1, 4'd0, 1, 1, 1, "R4", "R9");
        step(1, 4'd0, 1, 1, 0, "R3", "R9");
        // 10 Mb/s: no set
        step(1, 4'd0, 0, 0, 0, "R3", "R8");
        step(1, 4'd0, 0, 0, 0, "R3", "R8");
        // Loss during the clearing read
        step(1, 4'd0, 0, 1, 0, "R3", "R7");
        step(1, 4'd0, 0, 1, 1, "R4", "R9");
        step(1, 4'd0, 1, 1, 0, "R3", "R9");
        // Loss arriving on the read cycle from a clear flag
        step(1, 4'd0, 1, 1, 1, "R4", "R9");
        step(1, 4'd0, 0, 1, 1, "R4", "R9");

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            logic en, ok, m, rd;
            logic [3:0] c;
            en = ($urandom_range(9, 0) != 0);
            c  = 4'($urandom_range(8, 0));
            ok = ($urandom_range(4, 0) != 0);
            m  = ($urandom_range(9, 0) < 7);
            rd = ($urandom_range(6, 0) == 0);
            step(en, c, ok, m, rd, "R2", "R7");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule